// File: doc/BRIEF.md
# Command-Status Flash Bank Programmer

This block runs the complete erase or program sequence on one bank of a byte-wide flash. The device accepts command bytes written to its address space and reports progress through a status byte. A start pulse selects either an erase or a program operation and names a bank. The block then issues the command writes, waits on the device by repeatedly requesting and reading the status byte, and stops waiting after a bounded number of attempts. A fixed two-write epilogue clears the status and returns the device to array mode.

After the epilogue, the block reads the whole bank back. An erased bank must read as all ones. A programmed bank must equal the source buffer, which the block reads through its own one-cycle-latency read port. When the sequence ends, one result code reports success or the first cause of failure. The code stays valid until the next operation is accepted. The flash bus is a simple synchronous port: one write or one read strobe per cycle, with read data returned on the following cycle.

Top module: `cmdflash_bank_prog`

## Requirements
- R1: An erase (op = 0) begins with a write of 0x20 and, in the next cycle, a write of 0xD0, both to the bank base address; after that the device status is polled.
- R2: One poll attempt is a write of 0x70 to the bank base followed in the next cycle by a read of the bank base. The wait ends when bit 7 of the returned byte is 1; otherwise another attempt follows.
- R3: If POLL_LIMIT consecutive attempts all return bit 7 = 0, polling stops and the result code is 1 (timeout).
- R4: A program (op = 1) handles bytes in increasing offset order. For each byte it writes 0x40 to the target address, then writes the source byte for that offset to the same address GAP_CYCLES+2 cycles after the 0x40 write, then polls.
- R5: A timeout while programming ends the byte loop at once: no 0x40 write for any later offset follows.
- R6: Every operation, including one that timed out, finishes its device work with a write of 0xFF to the bank base, which the next cycle follows a write of 0x50 to the bank base before it. In cycle order: 0x50 first, then 0xFF.
- R7: After the epilogue, every offset of the bank is read in increasing order. After an erase, any byte that is not 0xFF gives result code 3 (verify mismatch).
- R8: After a program, any read-back byte that differs from the source byte at the same offset gives result code 3.
- R9: A completed status byte (bit 7 = 1) with any bit of mask 0x38 set gives result code 2 (device error). The operation continues normally.
- R10: Result codes are 0 none, 1 timeout, 2 device error, 3 verify mismatch, with priority 1 over 2 over 3. `done` is high for exactly one cycle, and `err` holds its value from that cycle until the next start is accepted.
- R11: A start while `busy` is high, including in the `done` cycle, is ignored.
- R12: Flash addresses are {bank, offset}, and `fl_we` and `fl_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 1 | 0 erase, 1 program |
| bank | input | BANK_W | Bank to operate on |
| busy | output | 1 | Operation in progress (high through the done cycle) |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 2 | Result code |
| src_addr | output | ADDR_W | Source buffer offset |
| src_rd | output | 1 | Source buffer read strobe |
| src_data | input | 8 | Source byte, valid the cycle after src_rd |
| fl_addr | output | BANK_W+ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, valid the cycle after fl_re |

## Verification
A new start request can coincide with the cycle in which `done` is raised, and it can also arrive in the middle of a poll loop. The bench deliberately pulses start at both moments, with the opposite op code. It then judges the outcome cycle by cycle against its reference sequence of bus transactions: no unexpected bus cycle may appear, and `busy` must be low afterwards with the original result code unchanged. A status byte that reports completion and a device error together, in a run whose read-back also mismatches, exercises the result priority.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
   localparam logic [7:0] CMD_ERASE_ARM  = 8'h20;
   localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
   localparam logic [7:0] CMD_PROG_ARM   = 8'h40;
   localparam logic [7:0] CMD_STATUS_QRY = 8'h70;
   localparam logic [7:0] CMD_STATUS_CLR = 8'h50;
   localparam logic [7:0] CMD_ARRAY_MODE = 8'hFF;
   localparam logic [7:0] ERASED_BYTE    = 8'hFF;
   localparam logic [7:0] STAT_ERR_MASK  = 8'h38;
   localparam int         STAT_DONE_BIT  = 7;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_DEVICE  = 2'd2,
      ERR_VERIFY  = 2'd3
   } cfp_err_e;

   typedef enum logic [3:0] {
      S_IDLE, S_E_ARM, S_E_GO, S_P_ARM, S_P_GAP, S_P_SRC, S_P_DATA,
      S_Q_CMD, S_Q_RD, S_Q_CHK, S_CLR, S_RST, S_V_RD, S_V_CHK, S_DONE
   } cfp_state_e;
endpackage

// File: rtl/cfp_cycle_timer.sv
module cfp_cycle_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   generate
      if (CYCLES <= 1) begin : g_single
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ load;
         assign expired   = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (load)       cnt <= CW'(CYCLES - 1);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign expired = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/cfp_attempt_counter.sv
module cfp_attempt_counter #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == TOP);
endmodule

// File: rtl/cmdflash_bank_prog.sv
module cmdflash_bank_prog
   import cfp_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int BANK_W     = 1,
   parameter int GAP_CYCLES = 250,
   parameter int POLL_LIMIT = 1000000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     op,
   input  logic [BANK_W-1:0]        bank,
   output logic                     busy,
   output logic                     done,
   output logic [1:0]               err,
   output logic [ADDR_W-1:0]        src_addr,
   output logic                     src_rd,
   input  logic [7:0]               src_data,
   output logic [BANK_W+ADDR_W-1:0] fl_addr,
   output logic [7:0]               fl_wdata,
   output logic                     fl_we,
   output logic                     fl_re,
   input  logic [7:0]               fl_rdata
);
   localparam int FA_W    = BANK_W + ADDR_W;
   localparam bit HAS_GAP = (GAP_CYCLES > 0);

   generate
      if (ADDR_W < 1)     begin : g_bad_addr  $error("ADDR_W must be at least 1");     end
      if (BANK_W < 1)     begin : g_bad_bank  $error("BANK_W must be at least 1");     end
      if (POLL_LIMIT < 1) begin : g_bad_limit $error("POLL_LIMIT must be at least 1"); end
      if (GAP_CYCLES < 0) begin : g_bad_gap   $error("GAP_CYCLES must not be negative"); end
   endgenerate

   cfp_state_e st, st_nx;
   logic              op_q;
   logic [BANK_W-1:0] bank_q;
   logic [ADDR_W-1:0] idx;
   logic              tmo_q, dev_q, vfail_q;
   cfp_err_e          err_q;

   logic [FA_W-1:0] base_a, here_a;
   logic idx_last, stat_done, stat_bad, accept, v_bad;
   logic gap_load, gap_exp, att_clr, att_inc, att_last;

   assign base_a    = {bank_q, {ADDR_W{1'b0}}};
   assign here_a    = {bank_q, idx};
   assign idx_last  = &idx;
   assign stat_done = fl_rdata[STAT_DONE_BIT];
   assign stat_bad  = |(fl_rdata & STAT_ERR_MASK);
   assign accept    = (st == S_IDLE) && start;
   assign v_bad     = (fl_rdata != (op_q ? src_data : ERASED_BYTE));

   assign gap_load = (st == S_P_ARM);
   assign att_clr  = (st == S_E_GO) || (st == S_P_DATA);
   assign att_inc  = (st == S_Q_CHK) && !stat_done;

   cfp_cycle_timer #(.CYCLES(GAP_CYCLES)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(gap_load), .expired(gap_exp));

   cfp_attempt_counter #(.LIMIT(POLL_LIMIT)) u_att (
      .clk(clk), .rst_n(rst_n), .clr(att_clr), .inc(att_inc), .last(att_last));

   always_comb begin
      st_nx = st;
      unique case (st)
         S_IDLE:   if (start) st_nx = op ? S_P_ARM : S_E_ARM;
         S_E_ARM:  st_nx = S_E_GO;
         S_E_GO:   st_nx = S_Q_CMD;
         S_P_ARM:  st_nx = HAS_GAP ? S_P_GAP : S_P_SRC;
         S_P_GAP:  if (gap_exp) st_nx = S_P_SRC;
         S_P_SRC:  st_nx = S_P_DATA;
         S_P_DATA: st_nx = S_Q_CMD;
         S_Q_CMD:  st_nx = S_Q_RD;
         S_Q_RD:   st_nx = S_Q_CHK;
         S_Q_CHK: begin
            if (stat_done)     st_nx = (op_q && !idx_last) ? S_P_ARM : S_CLR;
            else if (att_last) st_nx = S_CLR;
            else               st_nx = S_Q_CMD;
         end
         S_CLR:    st_nx = S_RST;
         S_RST:    st_nx = S_V_RD;
         S_V_RD:   st_nx = S_V_CHK;
         S_V_CHK:  st_nx = idx_last ? S_DONE : S_V_RD;
         S_DONE:   st_nx = S_IDLE;
         default:  st_nx = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         op_q    <= 1'b0;
         bank_q  <= '0;
         idx     <= '0;
         tmo_q   <= 1'b0;
         dev_q   <= 1'b0;
         vfail_q <= 1'b0;
         err_q   <= ERR_NONE;
      end else begin
         st <= st_nx;
         if (accept) begin
            op_q    <= op;
            bank_q  <= bank;
            idx     <= '0;
            tmo_q   <= 1'b0;
            dev_q   <= 1'b0;
            vfail_q <= 1'b0;
            err_q   <= ERR_NONE;
         end
         if (st == S_Q_CHK) begin
            if (stat_done) begin
               if (stat_bad) dev_q <= 1'b1;
               if (op_q && !idx_last) idx <= idx + 1'b1;
            end else if (att_last) begin
               tmo_q <= 1'b1;
            end
         end
         if (st == S_RST) idx <= '0;
         if (st == S_V_CHK) begin
            if (v_bad) vfail_q <= 1'b1;
            if (!idx_last) idx <= idx + 1'b1;
            else if (tmo_q)             err_q <= ERR_TIMEOUT;
            else if (dev_q)             err_q <= ERR_DEVICE;
            else if (vfail_q || v_bad)  err_q <= ERR_VERIFY;
            else                        err_q <= ERR_NONE;
         end
      end
   end

   always_comb begin
      fl_we    = 1'b0;
      fl_re    = 1'b0;
      fl_addr  = base_a;
      fl_wdata = 8'h00;
      src_rd   = 1'b0;
      src_addr = idx;
      unique case (st)
         S_E_ARM:  begin fl_we = 1'b1; fl_wdata = CMD_ERASE_ARM; end
         S_E_GO:   begin fl_we = 1'b1; fl_wdata = CMD_ERASE_GO; end
         S_P_ARM:  begin fl_we = 1'b1; fl_addr = here_a; fl_wdata = CMD_PROG_ARM; end
         S_P_SRC:  src_rd = 1'b1;
         S_P_DATA: begin fl_we = 1'b1; fl_addr = here_a; fl_wdata = src_data; end
         S_Q_CMD:  begin fl_we = 1'b1; fl_wdata = CMD_STATUS_QRY; end
         S_Q_RD:   fl_re = 1'b1;
         S_CLR:    begin fl_we = 1'b1; fl_wdata = CMD_STATUS_CLR; end
         S_RST:    begin fl_we = 1'b1; fl_wdata = CMD_ARRAY_MODE; end
         S_V_RD:   begin fl_re = 1'b1; fl_addr = here_a; src_rd = op_q; end
         default:  ;
      endcase
   end

   assign busy = (st != S_IDLE);
   assign done = (st == S_DONE);
   assign err  = err_q;
endmodule

// File: rtl/cfp_bank_prog_chk.sv
module cfp_bank_prog_chk #(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic                     op,
   input logic [BANK_W-1:0]        bank,
   input logic                     busy,
   input logic                     done,
   input logic [1:0]               err,
   input logic [BANK_W+ADDR_W-1:0] fl_addr,
   input logic [7:0]               fl_wdata,
   input logic                     fl_we,
   input logic                     fl_re
);
   assert_bus_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   assert_erase_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !op) |=>
         (fl_we && fl_wdata == 8'h20 && fl_addr == {$past(bank), {ADDR_W{1'b0}}}));

   assert_program_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && op) |=>
         (fl_we && fl_wdata == 8'h40 && fl_addr == {$past(bank), {ADDR_W{1'b0}}}));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(err));

   assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

bind cmdflash_bank_prog cfp_bank_prog_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bank(bank), .busy(busy),
   .done(done), .err(err), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
   .fl_we(fl_we), .fl_re(fl_re));

// File: tb/cmdflash_bank_prog_bench.sv
module cmdflash_bank_prog_bench;
   localparam int AW = 3, BW = 1, GAP = 2, LIM = 4, NB = 1 << AW;
   localparam int T_ERASE = 1, T_SETUP = 2, T_DATA = 3, T_PCMD = 4, T_PRD = 5,
                  T_EPI = 6, T_VER = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic start = 1'b0, op_i = 1'b0;
   logic [BW-1:0] bank_i = '0;
   logic busy, done, src_rd, fl_we, fl_re;
   logic [1:0] err;
   logic [AW-1:0] src_addr;
   logic [7:0] src_data = 8'h00, fl_wdata, fl_rdata = 8'h00;
   logic [BW+AW-1:0] fl_addr;

   cmdflash_bank_prog #(.ADDR_W(AW), .BANK_W(BW), .GAP_CYCLES(GAP), .POLL_LIMIT(LIM))
   u_cmdflash_bank_prog (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .bank(bank_i),
      .busy(busy), .done(done), .err(err), .src_addr(src_addr), .src_rd(src_rd),
      .src_data(src_data), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we),
      .fl_re(fl_re), .fl_rdata(fl_rdata));

   int checks = 0, errors = 0;
   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", what, act, exp);
      end
   endtask

   // behavioural flash device and source buffer
   logic [7:0] mem  [0:2*NB-1];
   logic [7:0] srcm [0:NB-1];
   int poll_delay = 0, pend = 0, stuck_idx = -1, pending_cmd = 0;
   logic [7:0] errbits = 8'h00;
   bit stat_mode = 1'b0;

   always @(posedge clk) begin
      int bb;
      if (fl_we) begin
         if (pending_cmd == 2) begin
            mem[fl_addr] = mem[fl_addr] & fl_wdata;
            pend = poll_delay;
            pending_cmd = 0;
         end else if (pending_cmd == 1 && fl_wdata == 8'hD0) begin
            bb = int'(fl_addr[AW]);
            for (int i = 0; i < NB; i++) mem[bb*NB+i] = (i == stuck_idx) ? 8'h00 : 8'hFF;
            pend = poll_delay;
            pending_cmd = 0;
         end else begin
            pending_cmd = 0;
            case (fl_wdata)
               8'h20: pending_cmd = 1;
               8'h40: pending_cmd = 2;
               8'h70: stat_mode = 1'b1;
               8'hFF: stat_mode = 1'b0;
               default: ;
            endcase
         end
      end
      if (fl_re) begin
         if (stat_mode) begin
            fl_rdata <= (pend > 0) ? 8'h00 : (8'h80 | errbits);
            if (pend > 0) pend--;
         end else fl_rdata <= mem[fl_addr];
      end
      if (src_rd) src_data <= srcm[src_addr];
   end

   // reference transaction queue, compared on every clock
   int qk[$], qa[$], qd[$], qt[$];
   int cyc = 0, setup_cyc = 0;

   function automatic string tag_req(input int t);
      case (t)
         T_ERASE: return "R1 erase command";
         T_SETUP, T_DATA: return "R4 program byte";
         T_PCMD, T_PRD: return "R2 status poll";
         T_EPI: return "R6 epilogue";
         default: return "R7/R8 verify read";
      endcase
   endfunction

   always @(negedge clk) begin
      int k, a, d, t;
      if (rst_n) begin
         cyc++;
         if (fl_we && fl_re) check(1'b0, "R12 both strobes", 3, 1);
         else if (fl_we || fl_re) begin
            if (qk.size() == 0) check(1'b0, "R12 unexpected bus cycle", int'(fl_addr), -1);
            else begin
               k = qk.pop_front(); a = qa.pop_front(); d = qd.pop_front(); t = qt.pop_front();
               check((k == int'(fl_we)) && (a == int'(fl_addr)) && (k == 0 || d == int'(fl_wdata)),
                     $sformatf("%s (R12 bank address)", tag_req(t)),
                     {fl_we, 3'b0, 4'(fl_addr), fl_wdata}, {k[0], 3'b0, 4'(a), 8'(d)});
               if (t == T_SETUP) setup_cyc = cyc;
               if (t == T_DATA) check(cyc - setup_cyc == GAP + 2, "R4 arm-to-data spacing",
                                      cyc - setup_cyc, GAP + 2);
            end
         end
      end
   end

   task automatic push(input int k, input int a, input int d, input int t);
      qk.push_back(k); qa.push_back(a); qd.push_back(d); qt.push_back(t);
   endtask

   task automatic exp_poll(input int b, input int d, output bit tmo);
      int n;
      n = (d < LIM) ? d + 1 : LIM;
      for (int i = 0; i < n; i++) begin
         push(1, b, 8'h70, T_PCMD);
         push(0, b, 0, T_PRD);
      end
      tmo = (d >= LIM);
   endtask

   task automatic run_op(input bit op, input int bk, input int d, input logic [7:0] eb,
                         input int stuck, input bit poke, input int exp_err, input string nm);
      int b, n;
      bit tmo;
      poll_delay = d; errbits = eb; stuck_idx = stuck;
      b = bk * NB;
      if (!op) begin
         push(1, b, 8'h20, T_ERASE);
         push(1, b, 8'hD0, T_ERASE);
         exp_poll(b, d, tmo);
      end else begin
         for (int i = 0; i < NB; i++) begin
            push(1, b + i, 8'h40, T_SETUP);
            push(1, b + i, int'(srcm[i]), T_DATA);
            exp_poll(b, d, tmo);
            if (tmo) break;
         end
      end
      push(1, b, 8'h50, T_EPI);
      push(1, b, 8'hFF, T_EPI);
      for (int i = 0; i < NB; i++) push(0, b + i, 0, T_VER);

      @(negedge clk);
      op_i = op; bank_i = BW'(bk); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done) begin
         @(negedge clk);
         n++;
         start = (poke && n == 3);
         op_i  = ~op;
      end
      check(int'(err) == exp_err, $sformatf("R10 result code, %s", nm), int'(err), exp_err);
      check(qk.size() == 0, $sformatf("R6 sequence complete before done, %s", nm), qk.size(), 0);
      if (poke) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!done && !busy, $sformatf("R10 done lasts one cycle, %s", nm), {done, busy}, 0);
      repeat (3) @(negedge clk);
      check(!busy, $sformatf("R11 start during done ignored, %s", nm), busy, 0);
      check(int'(err) == exp_err, $sformatf("R10 result held, %s", nm), int'(err), exp_err);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit ok;
      srcm = '{8'h50, 8'h70, 8'hFF, 8'h00, 8'hA5, 8'h3C, 8'h0F, 8'hC3};
      for (int i = 0; i < 2*NB; i++) mem[i] = 8'h0F;
      repeat (3) @(negedge clk);
      check(!busy && !done && err == 2'd0, "R10 reset state", {busy, done, err}, 0);
      check(!fl_we && !fl_re && !src_rd, "R12 bus idle in reset", {fl_we, fl_re, src_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(1'b0, 0, 1, 8'h00, -1, 1'b0, 0, "erase bank0");
      ok = 1'b1;
      for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) ok = 1'b0;
      check(ok, "R1 bank0 erased", ok, 1);
      check(mem[NB] == 8'h0F, "R12 other bank untouched", mem[NB], 8'h0F);

      run_op(1'b1, 0, 0, 8'h00, -1, 1'b0, 0, "program bank0");
      ok = 1'b1;
      for (int i = 0; i < NB; i++) if (mem[i] != srcm[i]) ok = 1'b0;
      check(ok, "R4 bank0 holds source", ok, 1);

      run_op(1'b1, 1, 1, 8'h00, -1, 1'b0, 3, "R8 program without erase");
      run_op(1'b0, 1, 100, 8'h00, -1, 1'b1, 1, "R3 erase timeout with stray starts");
      run_op(1'b1, 0, 100, 8'h00, -1, 1'b0, 1, "R5 program timeout on first byte");
      run_op(1'b0, 0, 0, 8'h10, -1, 1'b0, 2, "R9 device error");
      run_op(1'b0, 1, 2, 8'h00, 5, 1'b0, 3, "R7 erase with stuck byte");
      run_op(1'b0, 0, 0, 8'h08, 2, 1'b1, 2, "R10 device error over mismatch");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule